// File: doc/BRIEF.md
# Resettable Programmable-Period Square-Wave Generator

This block turns a master tick stream into a slow square wave with a 50% duty cycle. Each master tick advances a free-running divide chain. The chain is a fixed power-of-two prescale followed by a selectable power-of-eight ratio. An output latch flips each time the chain completes half of the selected total count. A 3-bit select picks the ratio. At the default parameters the ratio is one of 1, 8, 64, 512, 4096, 2^15, 2^18 or 2^21, and the prescale is 1024.

A reset pin masks the output latch without ever touching the divide chain. While reset is held, the latch stays clear and the output sits at its inactive level. Once reset is released, the next output edge comes at the divide chain's next half-period boundary, so the output phase stays tied to the divider. Asserting reset partway through a pulse cuts that pulse short.

A single polarity bit sets both the sense of the reset pin and the sense of the output:

- With polarity 0, the reset pin is active-high and the output is driven straight from the latch.
- With polarity 1, the reset pin is active-low and the output is the inverse of the latch.

The reset pin is asynchronous to the clock and is synchronized on entry.

Top module: `sqgen_top`

## Requirements
- R1: While the system reset `rstN` is low, the divide count and the output latch are cleared. The output then reads 0 with polarity 0 and 1 with polarity 1.
- R2: The divide count advances by exactly one on each clock cycle where `masterTick` is 1. Cycles where it is 0 have no effect.
- R3: When reset is not asserted, the output is high for exactly as many master ticks as it is low. Each half-period is 2^(PRESCALE_LOG2 + RATIO_STEP_LOG2*sel - 1) ticks.
- R4: A select value `sel` (0..7) chooses the ratio 2^(RATIO_STEP_LOG2*sel). At the defaults this gives 1, 8, 64, 512, 4096, 2^15, 2^18 and 2^21 for sel 0 through 7.
- R5: With `polarity` = 0, a high level on `resetPin` clears the latch and holds the output at 0. The output is not inverted.
- R6: With `polarity` = 1, a low level on `resetPin` clears the latch and holds the output at 1. The output is the inverted latch.
- R7: Reset never alters the divide count. After reset is released, the next output edge occurs at the divide chain's next half-period boundary.
- R8: Asserting reset while the output is in its active half cuts that half short, returning the output to the inactive level.
- R9: `resetPin` passes through two synchronizing flops. A change on it reaches the output on the third rising clock edge after it is sampled, and not before.
- R10: After the system reset is released with ticks arriving every cycle, the first output edge comes after exactly one half-period of ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| masterTick | input | 1 | One-cycle master oscillator tick enable |
| resetPin | input | 1 | Asynchronous output reset; its sense is set by `polarity` |
| ratioSel | input | SEL_W (3) | Index of the programmable ratio |
| polarity | input | 1 | 0: reset active-high, output direct; 1: reset active-low, output inverted |
| waveOut | output | 1 | Square-wave output |

## Verification
The embedded assertions check four things on every cycle:

- the divide count moves only on a tick and by exactly one;
- an active reset strobe leaves the latch clear on the next edge;
- the latch changes only on a terminal strobe or a clear;
- a terminal strobe never occurs without a tick.

Only the bench scenarios can show the rest. These are the actual half-period lengths for each select value, equal high and low times, the three-edge reset latency, pulse truncation, the inverted mode and the phase continuity after reset release. The bench covers them with a behavioural model compared every clock and with explicit run-length measurements. The bench uses a prescale of 4 and a ratio step of 2, so that all eight select values run to completion.

// File: rtl/sqgen_pkg.sv
package sqgen_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // step the divide count
    logic toggle;   // flip the output latch
    logic clear;    // hold the output latch cleared
    logic invert;   // drive the inverted latch on the pin
  } divStrobe_t;

endpackage

// File: rtl/sqgen_ctrl.sv
module sqgen_ctrl
  import sqgen_pkg::*;
#(
  parameter int PRESCALE_LOG2   = 10,
  parameter int RATIO_STEP_LOG2 = 3,
  parameter int SEL_W           = 3,
  localparam int NUM_RATIOS     = 1 << SEL_W,
  localparam int CNT_W          = PRESCALE_LOG2 + RATIO_STEP_LOG2 * (NUM_RATIOS - 1) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterTick,
  input  logic             resetPin,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             polarity,
  input  logic [CNT_W-1:0] count,
  output divStrobe_t       strobe
);

  // Two-flop synchronizer for the reset pin (R9)
  logic syncA, syncB;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= resetPin;
      syncB <= syncA;
    end
  end

  // One half-period terminal detector per ratio (R3, R4)
  logic [NUM_RATIOS-1:0] termHit;
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_term
    localparam int LOW_BITS = PRESCALE_LOG2 + RATIO_STEP_LOG2 * g - 1;
    assign termHit[g] = &count[LOW_BITS-1:0];
  end

  always_comb begin
    strobe.advance = masterTick;
    strobe.toggle  = masterTick & termHit[ratioSel];
    strobe.clear   = syncB ^ polarity;  // R5 / R6: polarity flips reset sense
    strobe.invert  = polarity;
  end

endmodule

// File: rtl/sqgen_datapath.sv
module sqgen_datapath
  import sqgen_pkg::*;
#(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  output logic [CNT_W-1:0] count,
  output logic             waveOut
);

  logic outLatch;

  // Free-running divide count; reset pin never reaches it (R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobe.advance) count <= count + 1'b1;
  end

  // Output latch: clear has priority over toggle (R5, R6, R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outLatch <= 1'b0;
    else if (strobe.clear)  outLatch <= 1'b0;
    else if (strobe.toggle) outLatch <= ~outLatch;
  end

  assign waveOut = outLatch ^ strobe.invert;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> count == $past(count) + 1'b1);

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(count));

  a_r5_clear_forces_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !outLatch);

  a_r3_latch_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.toggle && !strobe.clear) |=> $stable(outLatch));

  a_r2_toggle_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toggle |-> strobe.advance);

endmodule

// File: rtl/sqgen_top.sv
module sqgen_top
  import sqgen_pkg::*;
#(
  parameter int PRESCALE_LOG2   = 10,
  parameter int RATIO_STEP_LOG2 = 3,
  parameter int SEL_W           = 3,
  localparam int NUM_RATIOS     = 1 << SEL_W,
  localparam int CNT_W          = PRESCALE_LOG2 + RATIO_STEP_LOG2 * (NUM_RATIOS - 1) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterTick,
  input  logic             resetPin,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             polarity,
  output logic             waveOut
);

  divStrobe_t       strobe;
  logic [CNT_W-1:0] count;

  sqgen_ctrl #(
    .PRESCALE_LOG2  (PRESCALE_LOG2),
    .RATIO_STEP_LOG2(RATIO_STEP_LOG2),
    .SEL_W          (SEL_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .masterTick(masterTick),
    .resetPin  (resetPin),
    .ratioSel  (ratioSel),
    .polarity  (polarity),
    .count     (count),
    .strobe    (strobe)
  );

  sqgen_datapath #(
    .CNT_W(CNT_W)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .count  (count),
    .waveOut(waveOut)
  );

endmodule

// File: tb/sqgen_top_test.sv
module sqgen_top_test;
  localparam int P  = 2;
  localparam int S  = 1;
  localparam int SW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, masterTick, resetPin, polarity, waveOut;
  logic [SW-1:0] ratioSel;

  sqgen_top #(.PRESCALE_LOG2(P), .RATIO_STEP_LOG2(S), .SEL_W(SW)) uut (
    .clk(clk), .rstN(rstN), .masterTick(masterTick), .resetPin(resetPin),
    .ratioSel(ratioSel), .polarity(polarity), .waveOut(waveOut)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string curReq = "R1";

  // Behavioural reference model
  longint mCnt;
  bit     mQ1, mQ2, mLatch;

  function automatic longint halfTicks(int sel);
    return longint'(1) << (P + S * sel - 1);
  endfunction

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: waveOut actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: update model at the edge, compare at the falling edge
  task automatic step();
    bit clr, term;
    @(posedge clk);
    if (!rstN) begin
      mCnt = 0; mQ1 = 0; mQ2 = 0; mLatch = 0;
    end else begin
      clr  = mQ2 ^ polarity;
      term = masterTick && ((mCnt % halfTicks(int'(ratioSel))) == halfTicks(int'(ratioSel)) - 1);
      if (clr)       mLatch = 0;
      else if (term) mLatch = ~mLatch;
      if (masterTick) mCnt++;
      mQ2 = mQ1;
      mQ1 = resetPin;
    end
    @(negedge clk);
    checkBit(curReq, waveOut, mLatch ^ polarity);
  endtask

  // Wait for a rising output, then measure high and low run lengths (ticks every cycle)
  task automatic measure(int sel, string req);
    int hi, lo;
    ratioSel = SW'(sel);
    masterTick = 1'b1;
    while (waveOut !== 1'b0) step();
    while (waveOut !== 1'b1) step();
    hi = 0;
    while (waveOut === 1'b1) begin step(); hi++; end
    lo = 0;
    while (waveOut === 1'b0) begin step(); lo++; end
    checkInt(req, hi, halfTicks(sel));
    checkInt(req, lo, halfTicks(sel));
  endtask

  initial begin
    int n;
    rstN = 1'b0; masterTick = 1'b1; resetPin = 1'b0; polarity = 1'b0; ratioSel = SW'(2);
    curReq = "R1";
    repeat (3) step();
    checkBit("R1", waveOut, 1'b0);
    polarity = 1'b1; resetPin = 1'b1;
    step();
    checkBit("R1", waveOut, 1'b1);
    polarity = 1'b0; resetPin = 1'b0;
    step();

    // R10: first edge after one half-period (8 ticks for sel 2)
    rstN = 1'b1; curReq = "R10";
    n = 0;
    while (waveOut !== 1'b1 && n < 100) begin step(); n++; end
    checkInt("R10", n, halfTicks(2));

    // R3, R4: every ratio gives equal halves of the right length
    curReq = "R4";
    for (int s = 0; s < (1 << SW); s++) measure(s, (s % 2 == 0) ? "R3" : "R4");

    // R2: sparse ticks, count ignores idle cycles
    curReq = "R2"; ratioSel = SW'(3);
    for (int i = 0; i < 600; i++) begin
      masterTick = (i % 3 == 0);
      step();
    end
    masterTick = 1'b1;

    // R9, R8: truncate an active pulse; latency of three edges
    curReq = "R8";
    while (waveOut !== 1'b0) step();
    while (waveOut !== 1'b1) step();
    step();
    resetPin = 1'b1;
    step(); step();
    checkBit("R9", waveOut, 1'b1);
    step();
    checkBit("R8", waveOut, 1'b0);

    // R5: held low during active-high reset
    curReq = "R5";
    for (int i = 0; i < 80; i++) begin
      step();
      checkBit("R5", waveOut, 1'b0);
    end
    // R7: release, next edge follows divider phase (model compare)
    resetPin = 1'b0; curReq = "R7";
    repeat (120) step();

    // R6: inverted mode, active-low reset
    polarity = 1'b1; resetPin = 1'b1; curReq = "R6";
    repeat (150) step();
    resetPin = 1'b0;
    repeat (3) step();
    for (int i = 0; i < 60; i++) begin
      step();
      checkBit("R6", waveOut, 1'b1);
    end
    resetPin = 1'b1; curReq = "R7";
    repeat (150) step();
    measure(1, "R6");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule